// File: doc/BRIEF.md
# Wrapping Burst Address Generator

This block produces the address and transfer-type sequence for one bus master as it runs a burst on a 32-bit pipelined bus. A burst is loaded with a start address, a transfer size and a burst type. The burst type selects a single transfer, an open-ended incrementing burst, a 4/8/16-beat incrementing burst or a 4/8/16-beat wrapping burst. From the load onward, the block drives the beat address, the transfer type, the beat index and flags for the final beat and the wrap beat.

The address moves on only when a beat is accepted. A beat is accepted when the ready input is high and the driven transfer type is a real beat. A hold request turns the current cycle into a BUSY cycle. During that cycle the address output already shows the next beat, and the beat is not consumed.

For wrapping bursts, the beat on which the address folds back to the bottom of its window is computed once, at load time, from the start offset inside that window. The result is presented throughout the burst. An open-ended burst runs until the user asks it to stop.

Top module: `wrap_burst_agen`

## Requirements
- R1: After reset the transfer type is IDLE (code 0), last_o and wrap_o are low, and the block stays idle until start is seen.
- R2: start is taken only while the block is idle. While a burst is running, start and all load inputs are ignored. The first cycle after a load drives NONSEQ (code 2) with beat index 0, whatever hold is.
- R3: The loaded address has its low bits cleared to the transfer size: bit 0 for halfword (size 1) and bits [1:0] for word (size 2). A size code of 3 is treated as word. Every beat address stays aligned to the size.
- R4: For SINGLE (burst code 0), INCR (1), INCR4 (3), INCR8 (5) and INCR16 (7), each accepted beat adds 1, 2 or 4 bytes (size 0, 1, 2) to the address.
- R5: For WRAP4 (2), WRAP8 (4) and WRAP16 (6), the next address keeps the bits above a window of beat-count × size-bytes. Inside that window the low bits increment modulo the window size.
- R6: wrap_pt_o equals the beat count minus the start offset in beats within the window. It is 0 when the offset is 0 or the type does not wrap. wrap_o is high on the beat whose index equals a nonzero wrap_pt_o. Example: WRAP4 of words from offset 1 gives 3, and from offset 3 gives 1.
- R7: The address and beat index advance only when ready is high and the transfer type is NONSEQ or SEQ. Otherwise both hold.
- R8: hold on any beat after the first drives BUSY (code 1), and the address output keeps showing the next beat. Without hold, later beats drive SEQ (code 3).
- R9: A fixed-length type (every code except 1) runs exactly its beat count (1, 4, 8 or 16) and ignores stop. last_o is high on the final beat, and after that beat is accepted the block returns to IDLE.
- R10: INCR never raises last_o or wrap_o. It ends, back to IDLE, on the first cycle with stop and ready both high, whether that cycle is a beat or BUSY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load a new burst (used only when idle) |
| start_addr | input | ADDR_W | Start address of the burst |
| size | input | 2 | Transfer size: 0 byte, 1 halfword, 2 word, 3 treated as word |
| burst | input | 3 | Burst type code |
| hold | input | 1 | Request a BUSY cycle in place of the next beat |
| stop | input | 1 | End an INCR burst |
| ready | input | 1 | Bus ready; a beat is accepted when high |
| trans_o | output | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| addr_o | output | ADDR_W | Current beat address |
| beat_o | output | 4 | Index of the current beat |
| wrap_pt_o | output | 4 | Beat index at which the wrap occurs (0 = none) |
| wrap_o | output | 1 | Current beat is the wrap beat |
| last_o | output | 1 | Current beat is the final beat of a fixed-length burst |

## Verification
Wrapping bursts are run from zero, middle and top-of-window offsets for each size. A wrong offset or window mask would either miss the fold-back or fold at the wrong beat, and the wrap flag would land elsewhere. Unaligned start addresses and the size code 3 are loaded, which exposes a design that keeps low address bits or drives byte-stepped addresses. Random hold, ready and stop mixes are applied, and start is pulsed during running bursts. A design that advanced on a BUSY or waited cycle, honoured a stop on a fixed burst, or reloaded mid-burst would then show a skipped or repeated address, or a wrong beat count.

// File: rtl/wrap_burst_agen.sv
module wrap_burst_agen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        size,
  input  logic [2:0]        burst,
  input  logic              hold,
  input  logic              stop,
  input  logic              ready,
  output logic [1:0]        trans_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [3:0]        beat_o,
  output logic [3:0]        wrap_pt_o,
  output logic              wrap_o,
  output logic              last_o
);
  localparam int BEAT_W = 4;
  localparam logic [1:0] T_IDLE = 2'd0, T_BUSY = 2'd1, T_NSEQ = 2'd2, T_SEQ = 2'd3;
  localparam logic [2:0] B_INCR = 3'd1;

  function automatic logic [4:0] blen(input logic [2:0] b);
    if (b == 3'd0) return 5'd1;
    if (b == B_INCR) return 5'd0;
    return 5'd1 << ({1'b0, b[2:1]} + 3'd1);
  endfunction

  logic              active, first;
  logic [ADDR_W-1:0] addr_q;
  logic [BEAT_W-1:0] beat_q, wrap_pt_q;
  logic [2:0]        burst_q;
  logic [1:0]        size_q;

  logic [1:0]        size_in;
  logic [4:0]        len_in, len_q;
  logic [ADDR_W-1:0] aligned_in, bytes, winmask, inc, next_addr;
  logic [BEAT_W-1:0] off_in, wrap_pt_in;
  logic              wrap_in, wrap_q, accept, ending;

  assign size_in    = (size == 2'd3) ? 2'd2 : size;
  assign len_in     = blen(burst);
  assign aligned_in = start_addr & ~((ADDR_W'(1) << size_in) - ADDR_W'(1));
  assign off_in     = BEAT_W'(start_addr >> size_in) & BEAT_W'(len_in - 5'd1);
  assign wrap_in    = !burst[0] && (burst[2:1] != 2'b00);
  assign wrap_pt_in = (wrap_in && off_in != '0) ? BEAT_W'(len_in) - off_in : '0;

  assign len_q     = blen(burst_q);
  assign wrap_q    = !burst_q[0] && (burst_q[2:1] != 2'b00);
  assign bytes     = ADDR_W'(1) << size_q;
  assign winmask   = (ADDR_W'(len_q) << size_q) - ADDR_W'(1);
  assign inc       = addr_q + bytes;
  assign next_addr = wrap_q ? ((addr_q & ~winmask) | (inc & winmask)) : inc;

  assign trans_o = !active ? T_IDLE : first ? T_NSEQ : hold ? T_BUSY : T_SEQ;
  assign accept  = active && ready && trans_o[1];
  assign last_o  = active && (burst_q != B_INCR) && (beat_q == BEAT_W'(len_q - 5'd1));
  assign wrap_o  = active && (wrap_pt_q != '0) && (beat_q == wrap_pt_q);
  assign ending  = (accept && last_o) || (active && ready && stop && burst_q == B_INCR);

  assign addr_o    = addr_q;
  assign beat_o    = beat_q;
  assign wrap_pt_o = wrap_pt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      first     <= 1'b0;
      addr_q    <= '0;
      beat_q    <= '0;
      wrap_pt_q <= '0;
      burst_q   <= '0;
      size_q    <= '0;
    end else if (!active) begin
      if (start) begin
        active    <= 1'b1;
        first     <= 1'b1;
        addr_q    <= aligned_in;
        beat_q    <= '0;
        wrap_pt_q <= wrap_pt_in;
        burst_q   <= burst;
        size_q    <= size_in;
      end
    end else if (ending) begin
      active <= 1'b0;
      first  <= 1'b0;
    end else if (accept) begin
      addr_q <= next_addr;
      beat_q <= beat_q + 1'b1;
      first  <= 1'b0;
    end
  end
endmodule

// File: rtl/wrap_burst_agen_chk.sv
module wrap_burst_agen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic [1:0]        trans_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [3:0]        beat_o,
  input logic              last_o,
  input logic              wrap_o,
  input logic              active,
  input logic [1:0]        size_q,
  input logic [2:0]        burst_q
);
  logic [4:0]        win_beats;
  logic [ADDR_W-1:0] win_mask;
  assign win_beats = 5'd1 << ({1'b0, burst_q[2:1]} + 3'd1);
  assign win_mask  = (ADDR_W'(win_beats) << size_q) - ADDR_W'(1);

  a_r2_first_is_beat0: assert property (@(posedge clk) disable iff (!rst_n)
    trans_o == 2'd2 |-> beat_o == 4'd0);

  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    trans_o != 2'd0 |-> ((size_q != 2'd1) || !addr_o[0]) && ((size_q != 2'd2) || addr_o[1:0] == 2'b00));

  a_r6_wrap_at_window_base: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |-> (addr_o & win_mask) == '0);

  a_r7_no_accept_no_move: assert property (@(posedge clk) disable iff (!rst_n)
    active && !(ready && trans_o[1]) |=> $stable(addr_o) && $stable(beat_o));

  a_r8_busy_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    trans_o == 2'd1 |=> $stable(addr_o));

  a_r9_last_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && ready && trans_o[1] |=> trans_o == 2'd0);

  a_r10_incr_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    active && burst_q == 3'd1 |-> !last_o && !wrap_o);
endmodule

bind wrap_burst_agen wrap_burst_agen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .trans_o(trans_o), .addr_o(addr_o),
  .beat_o(beat_o), .last_o(last_o), .wrap_o(wrap_o), .active(active),
  .size_q(size_q), .burst_q(burst_q)
);

// File: tb/wrap_burst_agen_test.sv
`timescale 1ns/1ps
module wrap_burst_agen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, hold = 1'b0, stop = 1'b0, ready = 1'b0;
  logic [31:0] start_addr = '0;
  logic [1:0]  size = '0;
  logic [2:0]  burst = '0;
  logic [1:0]  trans_o;
  logic [31:0] addr_o;
  logic [3:0]  beat_o, wrap_pt_o;
  logic        wrap_o, last_o;
  int checks = 0, fails = 0;
  bit reported = 0;

  always #2.5 clk = ~clk;

  wrap_burst_agen #(.ADDR_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .size(size),
    .burst(burst), .hold(hold), .stop(stop), .ready(ready), .trans_o(trans_o),
    .addr_o(addr_o), .beat_o(beat_o), .wrap_pt_o(wrap_pt_o), .wrap_o(wrap_o), .last_o(last_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
    end
    $finish;
  endtask

  function automatic int f_size(input logic [1:0] s);
    return (s == 2'd3) ? 2 : int'(s);
  endfunction
  function automatic int f_len(input logic [2:0] b);
    case (b)
      3'd0: return 1;
      3'd1: return 0;
      3'd2, 3'd3: return 4;
      3'd4, 3'd5: return 8;
      default: return 16;
    endcase
  endfunction
  function automatic bit f_wrap(input logic [2:0] b);
    return (b == 3'd2) || (b == 3'd4) || (b == 3'd6);
  endfunction
  function automatic int f_wpt(input logic [31:0] a, input logic [1:0] s, input logic [2:0] b);
    int off;
    if (!f_wrap(b)) return 0;
    off = int'((a >> f_size(s)) % f_len(b));
    return (off == 0) ? 0 : f_len(b) - off;
  endfunction
  function automatic logic [31:0] f_addr(input logic [31:0] a, input logic [1:0] s,
                                         input logic [2:0] b, input int k);
    logic [31:0] by, al, win;
    by  = 32'd1 << f_size(s);
    al  = a & ~(by - 1);
    if (!f_wrap(b)) return al + by * k;
    win = by * f_len(b);
    return (al & ~(win - 1)) | ((al + by * k) & (win - 1));
  endfunction

  task automatic run_burst(input logic [31:0] a, input logic [1:0] s, input logic [2:0] b,
                           input int hold_pct, input int ready_pct, input int nb);
    int  k = 0, cyc = 0, len = f_len(b), wpt = f_wpt(a, s, b);
    bit  done = 0, incr = (b == 3'd1), acc;
    int  etr;
    @(negedge clk);
    start = 1; start_addr = a; size = s; burst = b; hold = 0; stop = 0; ready = 1;
    @(negedge clk);
    while (!done && cyc < 400) begin
      hold  = ($urandom % 100) < hold_pct;
      ready = ($urandom % 100) < ready_pct;
      stop  = incr ? (k >= nb - 1) : ($urandom % 2 == 1);
      start = ($urandom % 4 == 0);
      start_addr = $urandom; burst = 3'($urandom); size = 2'($urandom);
      #1;
      etr = (k == 0) ? 2 : (hold ? 1 : 3);
      chk(trans_o == 2'(etr), (k == 0) ? "R2" : "R8", "trans", trans_o, etr);
      chk(addr_o == f_addr(a, s, b, k), (k == 0) ? "R3" : (f_wrap(b) ? "R5" : "R4"),
          "addr", addr_o, f_addr(a, s, b, k));
      chk(beat_o == 4'(k % 16), "R7", "beat", beat_o, k % 16);
      chk(last_o == (!incr && k == len - 1), incr ? "R10" : "R9", "last", last_o, !incr && k == len - 1);
      chk(wrap_o == (wpt != 0 && k == wpt), "R6", "wrap flag", wrap_o, wpt != 0 && k == wpt);
      if (k == 0) chk(wrap_pt_o == 4'(wpt), "R6", "wrap point", wrap_pt_o, wpt);
      acc = ready && etr >= 2;
      if (incr && ready && stop) done = 1;
      else if (acc && !incr && k == len - 1) done = 1;
      if (acc) k++;
      cyc++;
      @(negedge clk);
    end
    start = 0; stop = 0; hold = 0;
    #1;
    chk(trans_o == 2'd0, incr ? "R10" : "R9", "idle after burst", trans_o, 0);
    if (!incr) chk(k == len, "R9", "beat count", k, len);
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    #12 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    ready = 1;
    #1;
    chk(trans_o == 2'd0, "R1", "reset trans", trans_o, 0);
    chk(!last_o && !wrap_o, "R1", "reset flags", {last_o, wrap_o}, 0);
    @(negedge clk); #1;
    chk(trans_o == 2'd0, "R1", "idle without start", trans_o, 0);

    run_burst(32'h34, 2'd2, 3'd2, 0, 100, 1);
    run_burst(32'h3C, 2'd2, 3'd2, 0, 100, 1);
    run_burst(32'h30, 2'd2, 3'd2, 30, 70, 1);
    run_burst(32'h37, 2'd3, 3'd2, 30, 70, 1);
    run_burst(32'h1007, 2'd1, 3'd4, 30, 70, 1);
    run_burst(32'h2B, 2'd0, 3'd6, 40, 60, 1);
    run_burst(32'hFFC, 2'd2, 3'd7, 20, 80, 1);
    run_burst(32'h10, 2'd2, 3'd0, 100, 100, 1);
    run_burst(32'h100, 2'd2, 3'd1, 30, 70, 20);
    run_burst(32'h203, 2'd0, 3'd1, 0, 100, 1);
    for (int i = 0; i < 300; i++)
      run_burst($urandom, 2'($urandom), 3'($urandom), $urandom % 50, 40 + $urandom % 61,
                1 + $urandom % 24);
    report();
  end
endmodule